// File: doc/BRIEF.md
# Sized-Access General Register File

This block is a bank of sixteen 64-bit general registers. Any register can be read or written at an operand width of 8, 16, 32 or 64 bits. It serves as the integer register store of a small execution core. One combinational read port and one clocked write port are available, and each port takes a register index and a two-bit width code.

A read returns the low-order bits of the selected register at the requested width. The bits above that width are driven to zero on the 64-bit output bus. A write merges its data into the register, and the rule depends on the width:

- An 8-bit or 16-bit write keeps every bit above the written field.
- A 32-bit write clears the upper half of the register.
- A 64-bit write replaces the whole register.

The read port has no bypass. A read of the register being written in the same cycle returns the contents from before the write.

Top module: `gpr_sized_file`

## Requirements
- R1: The file holds 16 independent 64-bit registers, selected by index 0 to 15. A write to one index never changes any other register.
- R2: A synchronous, active-high `rst` clears every register to zero at the next rising clock edge.
- R3: The read width code selects 8 bits (00), 16 bits (01), 32 bits (10) or 64 bits (11). `rd_data` carries bits w-1..0 of the selected register and zeros above bit w-1.
- R4: A write with width code 10 (32 bits) stores `wr_data[31:0]` in bits 31..0 and sets bits 63..32 of the register to zero.
- R5: A write with width code 00 (8 bits) or 01 (16 bits) stores the low w bits of `wr_data` and leaves bits 63..w of the register unchanged.
- R6: A write with width code 11 (64 bits) replaces all 64 bits of the register with `wr_data`.
- R7: Bits of `wr_data` above the write width have no effect on the stored register.
- R8: While `wr_en` is low, no register changes, whatever the values on the other write inputs.
- R9: A read of the index being written in the same cycle returns the old contents. The new contents appear on a read in the following cycle.
- R10: The read is combinational. `rd_data` follows `rd_idx` and `rd_size` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| rd_idx | input | 4 | Read register index |
| rd_size | input | 2 | Read width code (00=8, 01=16, 10=32, 11=64 bits) |
| rd_data | output | 64 | Read data, zero above the read width |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write width code (00=8, 01=16, 10=32, 11=64 bits) |
| wr_data | input | 64 | Write data; only the low w bits are used |

## Verification
The clocked assertions assume that `wr_en`, `wr_idx`, `wr_size` and `wr_data` hold known values at every rising edge outside reset. They also assume that these inputs change only between edges, so that the value sampled at an edge is the value the write used. The bench meets both assumptions:

- It drives every input from a single driver task on the falling edge.
- It keeps all write inputs at defined values even when `wr_en` is low.
- It samples `rd_data` one nanosecond after that falling edge, well before the next rising edge, so each comparison sees the combinational result of the inputs just applied.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_D = 2'b11
  } gpr_size_e;

  // Number of bits covered by a width code.
  function automatic int unsigned lane_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/gpr_size_decode.sv
module gpr_size_decode #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size_code,
  output logic [XLEN-1:0] lane_mask,
  output logic            clear_upper
);
  import gpr_pkg::*;

  // Ones over the accessed low-order field, zeros above it.
  function automatic logic [XLEN-1:0] field_mask(input logic [1:0] code);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) begin
      m[i] = (i < int'(lane_bits(code)));
    end
    return m;
  endfunction

  always_comb begin
    lane_mask   = field_mask(size_code);
    clear_upper = (size_code == SZ_W);
  end

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_value,
  input  logic [XLEN-1:0] new_data,
  input  logic [XLEN-1:0] lane_mask,
  input  logic            clear_upper,
  output logic [XLEN-1:0] merged
);

  // Written field comes from new_data; the rest is kept unless cleared.
  function automatic logic [XLEN-1:0] merge_fn(
    input logic [XLEN-1:0] oldv,
    input logic [XLEN-1:0] datv,
    input logic [XLEN-1:0] msk,
    input logic            clr
  );
    logic [XLEN-1:0] keep;
    keep = clr ? '0 : ~msk;
    return (datv & msk) | (oldv & keep);
  endfunction

  always_comb merged = merge_fn(old_value, new_data, lane_mask, clear_upper);

endmodule

// File: rtl/gpr_read_select.sv
module gpr_read_select #(
  parameter int XLEN  = 64,
  parameter int NREGS = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][XLEN-1:0] regs,
  input  logic [IW-1:0]              idx,
  input  logic [XLEN-1:0]            lane_mask,
  output logic [XLEN-1:0]            data
);

  always_comb data = regs[idx] & lane_mask;

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int XLEN  = 64,
  parameter int NREGS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREGS-1:0]           wr_hit,
  input  logic [XLEN-1:0]            wr_value,
  input  logic [XLEN-1:0]            wr_mask,
  input  logic                       wr_clear_upper,
  output logic [NREGS-1:0][XLEN-1:0] regs_q
);
  localparam int HALF = XLEN / 2;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            regs_q[g] <= '0;
      else if (wr_hit[g]) regs_q[g] <= wr_value;
    end

    // R2: reset clears every register
    a_r2_reset_clear: assert property (@(posedge clk) rst |=> regs_q[g] == '0);

    // R8 / R1: a register not hit by a write holds its value
    a_r8_hold_unhit: assert property (@(posedge clk) disable iff (rst)
      !wr_hit[g] |=> $stable(regs_q[g]));

    // R4: a 32-bit write leaves the upper half zero
    a_r4_upper_clear: assert property (@(posedge clk) disable iff (rst)
      (wr_hit[g] && wr_clear_upper) |=> regs_q[g][XLEN-1:HALF] == '0);

    // R5: a narrow write keeps the bits above the field
    a_r5_upper_keep: assert property (@(posedge clk) disable iff (rst)
      (wr_hit[g] && !wr_clear_upper && !wr_mask[XLEN-1]) |=>
        ((regs_q[g] & ~$past(wr_mask)) == ($past(regs_q[g]) & ~$past(wr_mask))));
  end

endmodule

// File: rtl/gpr_sized_file.sv
module gpr_sized_file #(
  parameter int XLEN  = 64,
  parameter int NREGS = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   rd_idx,
  input  logic [1:0]      rd_size,
  output logic [XLEN-1:0] rd_data,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_size,
  input  logic [XLEN-1:0] wr_data
);
  import gpr_pkg::*;

  logic [NREGS-1:0][XLEN-1:0] regs_q;
  logic [XLEN-1:0]            wr_mask;
  logic                       wr_clear_upper;
  logic [XLEN-1:0]            wr_merged;
  logic [NREGS-1:0]           wr_hit;
  logic [XLEN-1:0]            rd_mask;
  logic                       rd_clear_unused;

  gpr_size_decode #(.XLEN(XLEN)) u_wdec (
    .size_code   (wr_size),
    .lane_mask   (wr_mask),
    .clear_upper (wr_clear_upper)
  );

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .old_value   (regs_q[wr_idx]),
    .new_data    (wr_data),
    .lane_mask   (wr_mask),
    .clear_upper (wr_clear_upper),
    .merged      (wr_merged)
  );

  // One-hot write select
  for (genvar g = 0; g < NREGS; g++) begin : g_hit
    assign wr_hit[g] = wr_en && (wr_idx == IW'(g));
  end

  gpr_bank #(.XLEN(XLEN), .NREGS(NREGS)) u_bank (
    .clk            (clk),
    .rst            (rst),
    .wr_hit         (wr_hit),
    .wr_value       (wr_merged),
    .wr_mask        (wr_mask),
    .wr_clear_upper (wr_clear_upper),
    .regs_q         (regs_q)
  );

  gpr_size_decode #(.XLEN(XLEN)) u_rdec (
    .size_code   (rd_size),
    .lane_mask   (rd_mask),
    .clear_upper (rd_clear_unused)
  );

  gpr_read_select #(.XLEN(XLEN), .NREGS(NREGS)) u_rsel (
    .regs      (regs_q),
    .idx       (rd_idx),
    .lane_mask (rd_mask),
    .data      (rd_data)
  );

  // R1: at most one register written per cycle
  a_r1_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));

  // R3: an 8-bit read is zero above bit 7
  a_r3_byte_pad: assert property (@(posedge clk) disable iff (rst)
    (rd_size == SZ_B) |-> rd_data[XLEN-1:8] == '0);

  // R3: a 32-bit read is zero in the upper half
  a_r3_word_pad: assert property (@(posedge clk) disable iff (rst)
    (rd_size == SZ_W) |-> rd_data[XLEN-1:XLEN/2] == '0);

  // R6: a 64-bit write stores the whole data word
  a_r6_full_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_D) |=> regs_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: tb/gpr_sized_file_tb.sv
`timescale 1ns/1ps
module gpr_sized_file_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_idx;
  logic [1:0]  rd_size;
  logic [63:0] rd_data;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_size;
  logic [63:0] wr_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [63:0] model [16];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  gpr_sized_file u_dut (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_size(rd_size), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data)
  );

  function automatic logic [63:0] exp_read(input logic [63:0] r, input logic [1:0] sz);
    case (sz)
      2'b00:   return {56'h0, r[7:0]};
      2'b01:   return {48'h0, r[15:0]};
      2'b10:   return {32'h0, r[31:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [63:0] exp_write(input logic [63:0] r, input logic [63:0] d,
                                            input logic [1:0] sz);
    case (sz)
      2'b00:   return {r[63:8], d[7:0]};
      2'b01:   return {r[63:16], d[15:0]};
      2'b10:   return {32'h0, d[31:0]};
      default: return d;
    endcase
  endfunction

  // Driver: one cycle, applied on the falling edge
  task automatic cyc(input bit we, input logic [3:0] widx, input logic [1:0] wsz,
                     input logic [63:0] wd, input bit re, input logic [3:0] ridx,
                     input logic [1:0] rsz, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = widx; wr_size = wsz; wr_data = wd;
    rd_idx = ridx; rd_size = rsz;
    if (re) begin
      exp_q.push_back(exp_read(model[ridx], rsz));
      tag_q.push_back(tag);
    end
    if (we) model[widx] = exp_write(model[widx], wd, wsz);
  endtask

  task automatic wr(input logic [3:0] i, input logic [1:0] sz, input logic [63:0] d,
                    input string tag);
    cyc(1, i, sz, d, 0, 4'd0, 2'b11, tag);
  endtask

  task automatic rd(input logic [3:0] i, input logic [1:0] sz, input string tag);
    cyc(0, 4'd0, 2'b11, 64'hDEAD_BEEF_0BAD_F00D, 1, i, sz, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
  endtask

  // Monitor: compare one expected item per cycle, mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (rd_data !== e) begin
          miscompares++;
          $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = 2'b11; wr_data = '0;
    rd_idx = '0; rd_size = 2'b11;
    for (int i = 0; i < 16; i++) model[i] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;

    // R2: reset state, all registers zero
    for (int i = 0; i < 16; i++) rd(4'(i), 2'b11, "R2 reset value");

    // R6 / R1: full writes with distinct patterns, then read every one back
    for (int i = 0; i < 16; i++)
      wr(4'(i), 2'b11, 64'h0123_4567_89AB_CDEF ^ {16{4'(i)}} ^ (64'(i) << 60), "R6");
    for (int i = 0; i < 16; i++) rd(4'(i), 2'b11, "R1/R6 independent full write");

    // R3 / R10: each read width on one register, index and width changing per cycle
    wr(4'd5, 2'b11, 64'hF1E2_D3C4_B5A6_9788, "R6");
    rd(4'd5, 2'b00, "R3 8-bit read");
    rd(4'd5, 2'b01, "R3 16-bit read");
    rd(4'd5, 2'b10, "R3 32-bit read");
    rd(4'd5, 2'b11, "R3 64-bit read");
    rd(4'd6, 2'b00, "R10 combinational read other index");
    rd(4'd5, 2'b10, "R10 combinational read back");

    // R5 / R7: narrow writes with garbage above the field
    wr(4'd3, 2'b00, 64'hAAAA_AAAA_AAAA_AA5C, "R5");
    rd(4'd3, 2'b11, "R5/R7 8-bit write keeps upper");
    wr(4'd4, 2'b01, 64'h5555_5555_5555_BEEF, "R5");
    rd(4'd4, 2'b11, "R5/R7 16-bit write keeps upper");

    // R4: 32-bit write clears upper half
    wr(4'd7, 2'b10, 64'hCAFE_CAFE_1234_5678, "R4");
    rd(4'd7, 2'b11, "R4 32-bit write clears upper");
    rd(4'd8, 2'b11, "R1 neighbour untouched");

    // R8: wr_en low with live write inputs
    cyc(0, 4'd9, 2'b11, 64'h0, 0, 4'd0, 2'b11, "R8");
    rd(4'd9, 2'b11, "R8 disabled write has no effect");

    // R9: same-cycle read returns old contents; new next cycle
    cyc(1, 4'd10, 2'b11, 64'h7777_8888_9999_AAAA, 1, 4'd10, 2'b11, "R9 same-cycle old value");
    rd(4'd10, 2'b11, "R9 next-cycle new value");
    cyc(1, 4'd11, 2'b00, 64'h0000_0000_0000_00EE, 1, 4'd11, 2'b00, "R9 narrow same-cycle old");
    rd(4'd11, 2'b11, "R9/R5 narrow next-cycle value");

    // R4 then R5 on the same register
    wr(4'd12, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    wr(4'd12, 2'b10, 64'h0, "R4");
    wr(4'd12, 2'b01, 64'hFFFF_FFFF_FFFF_1234, "R5");
    rd(4'd12, 2'b11, "R4/R5 sequence");

    // R2: reset mid-run clears written state
    do_reset();
    for (int i = 0; i < 16; i++) rd(4'(i), 2'b11, "R2 reset clears all");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule